// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block steps a processor-style core through four power states: Normal, Stop-Grant, Sleep and Deep Sleep. Three active-low request inputs drive it: stop-clock, sleep and deep-sleep. They arrive asynchronously to the always-running reference clock that clocks the controller. A fourth input carries the raw bus clock as a monitor signal. The controller watches that signal for toggling, so it can tell when the bus clock has been stopped.

The controller keeps to a strict ladder. A sleep request only counts while the block is in Stop-Grant. Deep Sleep is reached only from Sleep, either on request or when the bus clock disappears. Climbing back up also goes one rung at a time. From the current state the block drives:
- separate enables for the core-unit clocks, the bus and interrupt-controller clocks, and the PLL;
- two flags that permit snoop and interrupt servicing;
- a single-cycle acknowledge toward the bus interface when Stop-Grant is granted.

Reset is synchronous and active-high. From any state it returns the block to Normal.

Top module: `pwr_ladder_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it, the block is in Normal: core_clk_en, bus_clk_en, pll_en, snoop_en and intr_en are all 1 and sg_ack is 0. Every enable and flag is active-high.
- R2: A low level on stop_req_n in Normal moves the block to Stop-Grant. The change shows on the outputs after the third rising clock edge following the input change, not after the second. In Stop-Grant, core_clk_en is 0 and bus_clk_en, pll_en, snoop_en and intr_en are 1.
- R3: sg_ack is 1 for exactly one cycle, the first cycle of Stop-Grant, when Stop-Grant is entered from Normal. It is 1 at no other time.
- R4: In Stop-Grant, a high level on stop_req_n returns the block to Normal, with all enables and flags at 1. This takes priority over a pending sleep request.
- R5: A low level on sleep_req_n has no effect in Normal. In Stop-Grant it moves the block to Sleep, where pll_en is 1 and core_clk_en, bus_clk_en, snoop_en and intr_en are 0.
- R6: In Sleep, changes on stop_req_n have no effect on any output.
- R7: In Sleep, a high level on sleep_req_n returns the block to Stop-Grant without an sg_ack pulse.
- R8: In Sleep, a low level on dsleep_req_n moves the block to Deep Sleep, where every enable and flag is 0. In Normal and Stop-Grant, dsleep_req_n has no effect.
- R9: The bus clock counts as stopped once bclk_mon, after synchronization, shows no level change for 8 consecutive reference-clock cycles. A stopped bus clock in Sleep moves the block to Deep Sleep. While bclk_mon keeps changing, no such move happens.
- R10: Deep Sleep returns to Sleep only when dsleep_req_n is high and the bus clock is running. Either condition alone keeps the block in Deep Sleep.
- R11: A reset asserted in any state puts the block in Normal after the next rising clock edge.
- R12: In Sleep, if a deep-sleep request and a sleep release arrive in the same cycle, the block goes to Deep Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_n | input | 1 | Asynchronous stop-clock request, active low |
| sleep_req_n | input | 1 | Asynchronous sleep request, active low |
| dsleep_req_n | input | 1 | Asynchronous deep-sleep request, active low |
| bclk_mon | input | 1 | Raw bus clock, monitored for toggling |
| core_clk_en | output | 1 | Clock enable for the core units |
| bus_clk_en | output | 1 | Clock enable for the bus and interrupt-controller units |
| pll_en | output | 1 | PLL enable |
| sg_ack | output | 1 | One-cycle Stop-Grant acknowledge |
| snoop_en | output | 1 | Snoops may be serviced |
| intr_en | output | 1 | Interrupts may be serviced |

## Verification
Each request passes through two synchronizer flops and then the state register. Its effect therefore reaches the outputs after the third rising edge. The bench changes inputs at a falling edge and samples at the falling edge after that third rise. It also samples one edge earlier to confirm the old state still holds. sg_ack is registered together with the state, so it is checked in that same first Stop-Grant sample and again one cycle later, when it must be low. Bus-clock loss takes about twelve cycles, counting synchronizer, edge detector and idle counter. The bench can only stop the monitored clock to within a couple of cycles, so it checks for no change at eight cycles and for Deep Sleep at sixteen.

// File: rtl/pwr_ladder_pkg.sv
package pwr_ladder_pkg;

    localparam int SYNC_STAGES_DEF = 2;
    localparam int BCLK_IDLE_DEF   = 8;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_GRANT  = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_DEEP   = 2'd3
    } pstate_e;

    typedef struct packed {
        logic core;
        logic bus;
        logic pll;
        logic snoop;
        logic intr;
    } pwr_en_t;

    typedef struct packed {
        logic stop;
        logic sleep;
        logic deep;
    } req_t;

    function automatic pwr_en_t state_enables(pstate_e st);
        pwr_en_t en;
        case (st)
            ST_NORMAL: en = '{core: 1'b1, bus: 1'b1, pll: 1'b1, snoop: 1'b1, intr: 1'b1};
            ST_GRANT:  en = '{core: 1'b0, bus: 1'b1, pll: 1'b1, snoop: 1'b1, intr: 1'b1};
            ST_SLEEP:  en = '{core: 1'b0, bus: 1'b0, pll: 1'b1, snoop: 1'b0, intr: 1'b0};
            default:   en = '{core: 1'b0, bus: 1'b0, pll: 1'b0, snoop: 1'b0, intr: 1'b0};
        endcase
        return en;
    endfunction

endpackage

// File: rtl/req_sync.sv
module req_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d_async[b]};
            end
        end
        assign q_sync[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/bclk_watch.sv
module bclk_watch #(
    parameter int IDLE_LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_sync,
    output logic bclk_stopped
);

    localparam int CW = $clog2(IDLE_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_LIMIT);

    logic          bclk_prev;
    logic          edge_seen;
    logic [CW-1:0] idle_cnt;

    assign edge_seen = bclk_sync ^ bclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_prev <= 1'b0;
            idle_cnt  <= '0;
        end else begin
            bclk_prev <= bclk_sync;
            if (edge_seen) begin
                idle_cnt <= '0;
            end else if (idle_cnt != LIMIT) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    assign bclk_stopped = (idle_cnt == LIMIT);

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_ladder_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  req_t    req,
    input  logic    bclk_stopped,
    output pstate_e state,
    output logic    ack
);

    pstate_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_NORMAL: if (req.stop) nxt = ST_GRANT;
            ST_GRANT: begin
                if (!req.stop)      nxt = ST_NORMAL;
                else if (req.sleep) nxt = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (req.deep || bclk_stopped) nxt = ST_DEEP;
                else if (!req.sleep)          nxt = ST_GRANT;
            end
            default: if (!req.deep && !bclk_stopped) nxt = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_NORMAL;
            ack   <= 1'b0;
        end else begin
            state <= nxt;
            ack   <= (state == ST_NORMAL) && (nxt == ST_GRANT);
        end
    end

endmodule

// File: rtl/pwr_ladder_ctrl.sv
module pwr_ladder_ctrl
    import pwr_ladder_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int BCLK_IDLE   = BCLK_IDLE_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_req_n,
    input  logic sleep_req_n,
    input  logic dsleep_req_n,
    input  logic bclk_mon,
    output logic core_clk_en,
    output logic bus_clk_en,
    output logic pll_en,
    output logic sg_ack,
    output logic snoop_en,
    output logic intr_en
);

    localparam int NSIG = 4;
    localparam logic [NSIG-1:0] SYNC_RST = 4'b0111;

    logic [NSIG-1:0] raw_in;
    logic [NSIG-1:0] syn_in;
    logic            bclk_stopped;
    req_t            req;
    pstate_e         state;
    pwr_en_t         en;

    assign raw_in = {bclk_mon, dsleep_req_n, sleep_req_n, stop_req_n};

    req_sync #(
        .WIDTH  (NSIG),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(raw_in),
        .q_sync (syn_in)
    );

    assign req.stop  = ~syn_in[0];
    assign req.sleep = ~syn_in[1];
    assign req.deep  = ~syn_in[2];

    bclk_watch #(
        .IDLE_LIMIT(BCLK_IDLE)
    ) u_watch (
        .clk         (clk),
        .rst         (rst),
        .bclk_sync   (syn_in[3]),
        .bclk_stopped(bclk_stopped)
    );

    pwr_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .bclk_stopped(bclk_stopped),
        .state       (state),
        .ack         (sg_ack)
    );

    assign en          = state_enables(state);
    assign core_clk_en = en.core;
    assign bus_clk_en  = en.bus;
    assign pll_en      = en.pll;
    assign snoop_en    = en.snoop;
    assign intr_en     = en.intr;

endmodule

// File: rtl/pwr_ladder_ctrl_chk.sv
module pwr_ladder_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic core_clk_en,
    input logic bus_clk_en,
    input logic pll_en,
    input logic sg_ack,
    input logic snoop_en,
    input logic intr_en
);

    AST_RESET_NORMAL: assert property (@(posedge clk)
        rst |=> core_clk_en && bus_clk_en && pll_en && snoop_en && intr_en && !sg_ack); // R11

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sg_ack |=> !sg_ack); // R3

    AST_ACK_IN_GRANT: assert property (@(posedge clk) disable iff (rst)
        sg_ack |-> !core_clk_en && bus_clk_en && $past(core_clk_en)); // R3

    AST_GRANT_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (bus_clk_en && !core_clk_en) |-> snoop_en && intr_en && pll_en); // R2

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_clk_en |-> !snoop_en && !intr_en && !core_clk_en); // R5

    AST_CORE_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        ($rose(core_clk_en) && !$past(rst)) |-> $past(bus_clk_en)); // R4

    AST_PLL_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        ($rose(pll_en) && !$past(rst)) |-> !bus_clk_en); // R10

endmodule

bind pwr_ladder_ctrl pwr_ladder_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_clk_en(core_clk_en),
    .bus_clk_en (bus_clk_en),
    .pll_en     (pll_en),
    .sg_ack     (sg_ack),
    .snoop_en   (snoop_en),
    .intr_en    (intr_en)
);

// File: tb/pwr_ladder_ctrl_bench.sv
module pwr_ladder_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] EXP_NORMAL = 5'b11111;
    localparam logic [4:0] EXP_GRANT  = 5'b01111;
    localparam logic [4:0] EXP_SLEEP  = 5'b00100;
    localparam logic [4:0] EXP_DEEP   = 5'b00000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req_n = 1'b1;
    logic sleep_req_n = 1'b1;
    logic dsleep_req_n = 1'b1;
    logic bclk_mon = 1'b0;
    logic bclk_run = 1'b1;
    logic bclk_phase = 1'b0;
    logic core_clk_en, bus_clk_en, pll_en, sg_ack, snoop_en, intr_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (bclk_run) begin
            bclk_phase <= ~bclk_phase;
            if (bclk_phase) bclk_mon <= ~bclk_mon;
        end
    end

    pwr_ladder_ctrl u_pwr_ladder_ctrl (
        .clk         (clk),
        .rst         (rst),
        .stop_req_n  (stop_req_n),
        .sleep_req_n (sleep_req_n),
        .dsleep_req_n(dsleep_req_n),
        .bclk_mon    (bclk_mon),
        .core_clk_en (core_clk_en),
        .bus_clk_en  (bus_clk_en),
        .pll_en      (pll_en),
        .sg_ack      (sg_ack),
        .snoop_en    (snoop_en),
        .intr_en     (intr_en)
    );

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk_en(string tag, logic [4:0] exp);
        logic [4:0] got;
        got = {core_clk_en, bus_clk_en, pll_en, snoop_en, intr_en};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s enables actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic chk_ack(string tag, logic exp);
        n_tests++;
        if (sg_ack !== exp) begin
            n_fail++;
            $display("FAIL %s sg_ack actual=%b expected=%b", tag, sg_ack, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        stop_req_n = 1'b1; sleep_req_n = 1'b1; dsleep_req_n = 1'b1;
        bclk_run = 1'b1;
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
    endtask

    task automatic go_sleep();
        stop_req_n = 1'b0; sleep_req_n = 1'b0;
        cyc(4);
        chk_en("R5 reach sleep", EXP_SLEEP);
    endtask

    task automatic t_reset();
        chk_en("R1 in reset", EXP_NORMAL);
        chk_ack("R1 in reset", 1'b0);
        rst = 1'b0;
        cyc(1);
        chk_en("R1 after reset", EXP_NORMAL);
        chk_ack("R1 after reset", 1'b0);
    endtask

    task automatic t_stop_grant();
        do_reset();
        stop_req_n = 1'b0;
        cyc(2);
        chk_en("R2 latency two edges", EXP_NORMAL);
        chk_ack("R3 not early", 1'b0);
        cyc(1);
        chk_en("R2 stop-grant", EXP_GRANT);
        chk_ack("R3 ack first cycle", 1'b1);
        cyc(1);
        chk_ack("R3 ack one cycle", 1'b0);
        dsleep_req_n = 1'b0;
        cyc(5);
        chk_en("R8 deep ignored in stop-grant", EXP_GRANT);
        dsleep_req_n = 1'b1;
        cyc(3);
        stop_req_n = 1'b1;
        cyc(3);
        chk_en("R4 back to normal", EXP_NORMAL);
        chk_ack("R3 no ack on exit", 1'b0);
        dsleep_req_n = 1'b0;
        cyc(5);
        chk_en("R8 deep ignored in normal", EXP_NORMAL);
        dsleep_req_n = 1'b1;
        cyc(3);
    endtask

    task automatic t_sleep_gate();
        do_reset();
        sleep_req_n = 1'b0;
        cyc(5);
        chk_en("R5 sleep ignored in normal", EXP_NORMAL);
        stop_req_n = 1'b0;
        cyc(3);
        chk_en("R2 grant before sleep", EXP_GRANT);
        chk_ack("R3 ack with sleep pending", 1'b1);
        cyc(1);
        chk_en("R5 sleep from grant", EXP_SLEEP);
        stop_req_n = 1'b1;
        cyc(5);
        chk_en("R6 stop release ignored in sleep", EXP_SLEEP);
        chk_ack("R6 no ack in sleep", 1'b0);
        sleep_req_n = 1'b1;
        cyc(3);
        chk_en("R7 sleep release to grant", EXP_GRANT);
        chk_ack("R7 no ack from sleep", 1'b0);
        cyc(1);
        chk_en("R4 grant then normal", EXP_NORMAL);
    endtask

    task automatic t_deep_req();
        do_reset();
        go_sleep();
        dsleep_req_n = 1'b0;
        cyc(2);
        chk_en("R8 deep latency", EXP_SLEEP);
        cyc(1);
        chk_en("R8 deep entered", EXP_DEEP);
        dsleep_req_n = 1'b1;
        cyc(3);
        chk_en("R10 deep exit to sleep", EXP_SLEEP);
    endtask

    task automatic t_bclk_loss();
        do_reset();
        go_sleep();
        bclk_run = 1'b0;
        cyc(8);
        chk_en("R9 not yet stopped", EXP_SLEEP);
        cyc(8);
        chk_en("R9 bus clock loss to deep", EXP_DEEP);
        dsleep_req_n = 1'b0;
        cyc(3);
        bclk_run = 1'b1;
        cyc(10);
        chk_en("R10 clock alone keeps deep", EXP_DEEP);
        dsleep_req_n = 1'b1;
        cyc(3);
        chk_en("R10 both met to sleep", EXP_SLEEP);
        cyc(20);
        chk_en("R9 running clock stays sleep", EXP_SLEEP);
        bclk_run = 1'b0;
        cyc(16);
        chk_en("R10 stopped clock keeps deep", EXP_DEEP);
        cyc(5);
        chk_en("R10 still deep", EXP_DEEP);
        bclk_run = 1'b1;
    endtask

    task automatic t_priority();
        do_reset();
        go_sleep();
        sleep_req_n = 1'b1;
        dsleep_req_n = 1'b0;
        cyc(3);
        chk_en("R12 deep wins over release", EXP_DEEP);
    endtask

    task automatic t_reset_any();
        rst = 1'b1;
        cyc(1);
        chk_en("R11 reset from deep", EXP_NORMAL);
        chk_ack("R11 reset ack low", 1'b0);
        cyc(1);
        rst = 1'b0;
        dsleep_req_n = 1'b1;
        cyc(3);
        do_reset();
        stop_req_n = 1'b0;
        cyc(4);
        rst = 1'b1;
        cyc(1);
        chk_en("R11 reset from grant", EXP_NORMAL);
        stop_req_n = 1'b1;
        cyc(2);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        cyc(2);
        t_reset();
        t_stop_grant();
        t_sleep_gate();
        t_deep_req();
        t_bclk_loss();
        t_priority();
        t_reset_any();
        cyc(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule